// File: doc/BRIEF.md
# Priority Round-Robin Cell Rate Scheduler

This block chooses, once every cell slot, which traffic shaper sends the next cell on a shared line. A cell slot is a fixed number of clock cycles. Each shaper has a priority, an average-rate fraction (numerator over denominator, in cells per slot) and a peak-rate minimum spacing in slots. Each shaper also has a group of channels linked to it, and each channel has an activity flag that says it has cells waiting. In every slot the scheduler finds the eligible shaper with the highest priority. When several eligible shapers share that priority, it picks among them in round-robin order. It then reports that shaper and one of its channels as a grant.

Any shaper can be marked as an idle-cell generator. A generator outranks every normal shaper and needs no active channel. It emits idle cells at its configured rate, which takes that share of the line away from data traffic. A shaper in aggregate mode divides its cells evenly among its active channels by rotating through them. A shaper outside aggregate mode always serves its lowest-numbered active channel. When no shaper is eligible, the slot still produces an idle grant. A grant is held at the outputs until the downstream side accepts it.

Top module: `cell_rate_sched`

## Requirements
- R1: With every grant accepted, a decision is made once per SLOT_CLKS clock cycles, and the first grant appears SLOT_CLKS cycles after reset is released.
- R2: While `gnt_valid` is high and `gnt_ready` is low, all grant outputs stay unchanged. After `gnt_ready` is seen high, the next decision is taken at that same clock edge if its slot has already elapsed.
- R3: Each shaper owns a credit counter. At every decision it gains the shaper's numerator. The shaper has credit when this sum is at least its denominator. A grant removes one denominator from the sum. A shaper that is not granted keeps at most one denominator of credit. A shaper with num 1 and den 4 that is alone and always eligible therefore gets one slot in four.
- R4: After a grant, a shaper with interval P is not eligible again for P-1 decisions, so its grants are at least P slots apart. An interval of 0 acts like 1.
- R5: Among eligible shapers, the one with the larger priority value wins.
- R6: Among eligible shapers with equal top priority, the search starts at the shaper after the last winner (of any kind) and takes the first one found. Right after reset, the search starts at shaper 0.
- R7: A shaper with its generator flag set ranks above every shaper without it. It is eligible without any active channel. When it wins, the grant shows `gnt_idle`=1, `gnt_shaper_vld`=1, its own index and channel 0.
- R8: In aggregate mode, a shaper's data grants rotate over its active channels, starting at the channel after the one it last served. Right after reset, the rotation starts at channel 0.
- R9: Outside aggregate mode, a shaper's data grant always names its lowest-numbered active channel.
- R10: A non-generator shaper with no active channel is never granted. A data grant (`gnt_idle`=0) always names a channel that was active at the decision. If no shaper is eligible, the grant shows `gnt_idle`=1, `gnt_shaper_vld`=0, shaper 0 and channel 0.
- R11: While reset is asserted, `gnt_valid` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cfg_prio | input | N*PRIO_W | Priority of each shaper; a larger value wins |
| cfg_num | input | N*RATE_W | Credit added to each shaper's counter per decision |
| cfg_den | input | N*RATE_W | Credit one cell costs each shaper |
| cfg_ivl | input | N*IVL_W | Minimum slot spacing between grants of each shaper |
| cfg_gen | input | N | Marks each shaper as an idle-cell generator |
| cfg_agg | input | N | Selects aggregate (rotating) channel service for each shaper |
| ch_active | input | N*CH | Flags the channels that have cells waiting; bit s*CH+c is channel c of shaper s |
| gnt_ready | input | 1 | Downstream accepts the current grant |
| gnt_valid | output | 1 | A grant is present |
| gnt_idle | output | 1 | The granted cell is an idle cell |
| gnt_shaper_vld | output | 1 | A shaper won the slot |
| gnt_shaper | output | SW | Index of the winning shaper |
| gnt_chan | output | CW | Channel within the winning shaper |

## Verification
The assertions check four properties on every cycle. A held grant must not change. Two fresh grants must be at least one slot apart. A data grant must name a channel that was active at the decision. A generator win or a win with no shaper must come out as an idle cell. The exact choice of winner cannot be seen one cycle at a time, because it depends on the credit history, the peak spacing, the tie rotation and the channel rotation. The bench shows these only over sequences of slots. It compares every grant against its own model, in directed cases for each rule and in random configurations.

// File: rtl/cell_rate_sched.sv
module cell_rate_sched #(
  parameter int N         = 4,
  parameter int CH        = 4,
  parameter int SLOT_CLKS = 8,
  parameter int PRIO_W    = 3,
  parameter int RATE_W    = 6,
  parameter int IVL_W     = 6,
  localparam int SW       = (N > 1) ? $clog2(N) : 1,
  localparam int CW       = (CH > 1) ? $clog2(CH) : 1
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [N*PRIO_W-1:0] cfg_prio,
  input  logic [N*RATE_W-1:0] cfg_num,
  input  logic [N*RATE_W-1:0] cfg_den,
  input  logic [N*IVL_W-1:0]  cfg_ivl,
  input  logic [N-1:0]        cfg_gen,
  input  logic [N-1:0]        cfg_agg,
  input  logic [N*CH-1:0]     ch_active,
  input  logic                gnt_ready,
  output logic                gnt_valid,
  output logic                gnt_idle,
  output logic                gnt_shaper_vld,
  output logic [SW-1:0]       gnt_shaper,
  output logic [CW-1:0]       gnt_chan
);
  localparam int CNT_W = (SLOT_CLKS > 2) ? $clog2(SLOT_CLKS) : 1;
  localparam int AW    = RATE_W + 1;
  localparam int EW    = PRIO_W + 1;

  logic [CNT_W-1:0] slot_cnt;
  logic [AW-1:0]    acc     [N];
  logic [IVL_W-1:0] ivl_cnt [N];
  logic [CW-1:0]    ch_ptr  [N];
  logic [SW-1:0]    rr_ptr;

  logic [AW-1:0]    sum  [N];
  logic [N-1:0]     elig;
  logic [CW-1:0]    pick [N];
  logic             win_found;
  logic [SW-1:0]    win;

  wire tick   = slot_cnt == CNT_W'(SLOT_CLKS - 1);
  wire decide = tick && (!gnt_valid || gnt_ready);

  always_comb begin
    logic         hit;
    logic [EW-1:0] best;
    int           k;
    for (int s = 0; s < N; s++) begin
      sum[s]  = acc[s] + AW'(cfg_num[s*RATE_W +: RATE_W]);
      elig[s] = (sum[s] >= AW'(cfg_den[s*RATE_W +: RATE_W])) && (ivl_cnt[s] == '0)
                && (cfg_gen[s] || (|ch_active[s*CH +: CH]));
      pick[s] = '0;
      hit     = 1'b0;
      for (int j = 0; j < CH; j++) begin
        k = cfg_agg[s] ? (int'(ch_ptr[s]) + 1 + j) % CH : j;
        if (!hit && ch_active[s*CH + k]) begin
          pick[s] = CW'(k);
          hit     = 1'b1;
        end
      end
    end
    win_found = 1'b0;
    win       = '0;
    best      = '0;
    for (int i = 0; i < N; i++) begin
      k = (int'(rr_ptr) + 1 + i) % N;
      if (elig[k] && (!win_found || {cfg_gen[k], cfg_prio[k*PRIO_W +: PRIO_W]} > best)) begin
        win_found = 1'b1;
        win       = SW'(k);
        best      = {cfg_gen[k], cfg_prio[k*PRIO_W +: PRIO_W]};
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      slot_cnt       <= '0;
      rr_ptr         <= SW'(N - 1);
      gnt_valid      <= 1'b0;
      gnt_idle       <= 1'b0;
      gnt_shaper_vld <= 1'b0;
      gnt_shaper     <= '0;
      gnt_chan       <= '0;
      for (int s = 0; s < N; s++) begin
        acc[s]     <= '0;
        ivl_cnt[s] <= '0;
        ch_ptr[s]  <= CW'(CH - 1);
      end
    end else begin
      if (decide)     slot_cnt <= '0;
      else if (!tick) slot_cnt <= slot_cnt + 1'b1;

      if (decide) begin
        gnt_valid      <= 1'b1;
        gnt_shaper_vld <= win_found;
        gnt_idle       <= !win_found || cfg_gen[win];
        gnt_shaper     <= win_found ? win : '0;
        gnt_chan       <= (win_found && !cfg_gen[win]) ? pick[win] : '0;
        if (win_found) rr_ptr <= win;
        for (int s = 0; s < N; s++) begin
          if (win_found && win == SW'(s)) begin
            acc[s]     <= sum[s] - AW'(cfg_den[s*RATE_W +: RATE_W]);
            ivl_cnt[s] <= (cfg_ivl[s*IVL_W +: IVL_W] == '0) ? '0
                          : cfg_ivl[s*IVL_W +: IVL_W] - 1'b1;
            if (!cfg_gen[s] && cfg_agg[s]) ch_ptr[s] <= pick[s];
          end else begin
            acc[s] <= (sum[s] > AW'(cfg_den[s*RATE_W +: RATE_W]))
                      ? AW'(cfg_den[s*RATE_W +: RATE_W]) : sum[s];
            if (ivl_cnt[s] != '0) ivl_cnt[s] <= ivl_cnt[s] - 1'b1;
          end
        end
      end else if (gnt_ready) begin
        gnt_valid <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/cell_rate_sched_chk.sv
module cell_rate_sched_chk #(
  parameter int N         = 4,
  parameter int CH        = 4,
  parameter int SLOT_CLKS = 8,
  localparam int SW       = (N > 1) ? $clog2(N) : 1,
  localparam int CW       = (CH > 1) ? $clog2(CH) : 1
) (
  input logic            clk,
  input logic            rst_n,
  input logic [N-1:0]    cfg_gen,
  input logic [N*CH-1:0] ch_active,
  input logic            gnt_ready,
  input logic            gnt_valid,
  input logic            gnt_idle,
  input logic            gnt_shaper_vld,
  input logic [SW-1:0]   gnt_shaper,
  input logic [CW-1:0]   gnt_chan
);
  logic [N*CH-1:0] act_q;
  logic [N-1:0]    gen_q;
  logic            valid_q;
  logic [15:0]     gap;

  wire rise = gnt_valid && !valid_q;
  wire act_hit = act_q[int'(gnt_shaper)*CH + int'(gnt_chan)];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_q   <= '0;
      gen_q   <= '0;
      valid_q <= 1'b0;
      gap     <= '0;
    end else begin
      act_q   <= ch_active;
      gen_q   <= cfg_gen;
      valid_q <= gnt_valid;
      gap     <= rise ? 16'd1 : ((gap == 16'hffff) ? gap : gap + 16'd1);
    end
  end

  AST_SLOT_GAP: assert property (@(posedge clk) disable iff (!rst_n)
    rise |-> gap >= 16'(SLOT_CLKS)); // R1
  AST_GRANT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    gnt_valid && !gnt_ready |=> gnt_valid
      && $stable({gnt_idle, gnt_shaper_vld, gnt_shaper, gnt_chan})); // R2
  AST_GEN_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    rise && gnt_shaper_vld && gen_q[gnt_shaper] |-> gnt_idle); // R7
  AST_DATA_ACTIVE: assert property (@(posedge clk) disable iff (!rst_n)
    rise && !gnt_idle |-> act_hit); // R10
  AST_NO_WINNER_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    gnt_valid && !gnt_shaper_vld |-> gnt_idle && gnt_shaper == '0); // R10
  AST_RESET_CLEAR: assert property (@(posedge clk)
    !rst_n |-> !gnt_valid); // R11
endmodule

bind cell_rate_sched cell_rate_sched_chk #(.N(N), .CH(CH), .SLOT_CLKS(SLOT_CLKS)) u_chk (
  .clk(clk), .rst_n(rst_n), .cfg_gen(cfg_gen), .ch_active(ch_active),
  .gnt_ready(gnt_ready), .gnt_valid(gnt_valid), .gnt_idle(gnt_idle),
  .gnt_shaper_vld(gnt_shaper_vld), .gnt_shaper(gnt_shaper), .gnt_chan(gnt_chan)
);

// File: tb/test_cell_rate_sched.sv
module test_cell_rate_sched;
  localparam int N = 4, CH = 4, SLOT = 8, PW = 3, RW = 6, IW = 6, SW = 2, CW = 2;

  logic clk = 1'b0, rst_n = 1'b0, gnt_ready = 1'b1;
  logic [N*PW-1:0] cfg_prio;
  logic [N*RW-1:0] cfg_num, cfg_den;
  logic [N*IW-1:0] cfg_ivl;
  logic [N-1:0]    cfg_gen, cfg_agg;
  logic [N*CH-1:0] ch_active;
  logic gnt_valid, gnt_idle, gnt_shaper_vld;
  logic [SW-1:0] gnt_shaper;
  logic [CW-1:0] gnt_chan;

  int b_prio[N], b_num[N], b_den[N], b_ivl[N], b_gen[N], b_agg[N], b_act[N];
  int m_acc[N], m_ivl[N], m_chp[N], m_rr;
  int checks = 0, errors = 0, cyc = 0;

  always #5 clk = ~clk;

  always_comb begin
    for (int s = 0; s < N; s++) begin
      cfg_prio[s*PW +: PW] = PW'(b_prio[s]);
      cfg_num[s*RW +: RW]  = RW'(b_num[s]);
      cfg_den[s*RW +: RW]  = RW'(b_den[s]);
      cfg_ivl[s*IW +: IW]  = IW'(b_ivl[s]);
      cfg_gen[s]           = b_gen[s][0];
      cfg_agg[s]           = b_agg[s][0];
      ch_active[s*CH +: CH] = CH'(b_act[s]);
    end
  end

  cell_rate_sched i_cell_rate_sched (.*);

  task automatic summary();
    $display("Result: errors=%0d of %0d checks", errors, checks);
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      checks++; errors++;
      $display("FAIL R1: watchdog expired, actual cycles=%0d expected under 150000", cyc);
      summary();
      $finish;
    end
  end

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic set_sh(int s, int pr, int nu, int de, int iv, int ge, int ag, int ac);
    b_prio[s] = pr; b_num[s] = nu; b_den[s] = de; b_ivl[s] = iv;
    b_gen[s] = ge; b_agg[s] = ag; b_act[s] = ac;
  endtask

  // reference scheduler built from the requirements
  task automatic model_step(output int ev, output int ei, output int es, output int ec);
    int sum[N], pk[N], el[N];
    int best, fnd, w, k, hit;
    for (int s = 0; s < N; s++) begin
      sum[s] = m_acc[s] + b_num[s];
      el[s] = (sum[s] >= b_den[s]) && (m_ivl[s] == 0) && (b_gen[s] != 0 || b_act[s] != 0);
      pk[s] = 0; hit = 0;
      for (int j = 0; j < CH; j++) begin
        k = (b_agg[s] != 0) ? (m_chp[s] + 1 + j) % CH : j;
        if (hit == 0 && b_act[s][k]) begin pk[s] = k; hit = 1; end
      end
    end
    fnd = 0; w = 0; best = 0;
    for (int i = 0; i < N; i++) begin
      k = (m_rr + 1 + i) % N;
      if (el[k] != 0 && (fnd == 0 || b_gen[k] * (1 << PW) + b_prio[k] > best)) begin
        fnd = 1; w = k; best = b_gen[k] * (1 << PW) + b_prio[k];
      end
    end
    ev = fnd;
    ei = (fnd == 0 || b_gen[w] != 0) ? 1 : 0;
    es = fnd ? w : 0;
    ec = (fnd != 0 && b_gen[w] == 0) ? pk[w] : 0;
    for (int s = 0; s < N; s++) begin
      if (fnd != 0 && s == w) begin
        m_acc[s] = sum[s] - b_den[s];
        m_ivl[s] = (b_ivl[s] == 0) ? 0 : b_ivl[s] - 1;
        if (b_gen[s] == 0 && b_agg[s] != 0) m_chp[s] = pk[s];
      end else begin
        m_acc[s] = (sum[s] > b_den[s]) ? b_den[s] : sum[s];
        if (m_ivl[s] != 0) m_ivl[s] = m_ivl[s] - 1;
      end
    end
    if (fnd != 0) m_rr = w;
  endtask

  int last_shp, last_vld;

  task automatic next_grant(string req, int check_gap);
    int ev, ei, es, ec, waited;
    waited = 0;
    @(negedge clk); waited++;
    while (!gnt_valid) begin @(negedge clk); waited++; end
    if (check_gap != 0) chk("R1 slot spacing", waited, SLOT);
    model_step(ev, ei, es, ec);
    checks++;
    if (gnt_shaper_vld !== ev[0] || gnt_idle !== ei[0] || gnt_shaper !== SW'(es) || gnt_chan !== CW'(ec)) begin
      errors++;
      $display("FAIL %s: vld/idle/shp/chan actual=%0d/%0d/%0d/%0d expected=%0d/%0d/%0d/%0d",
               req, gnt_shaper_vld, gnt_idle, gnt_shaper, gnt_chan, ev, ei, es, ec);
    end
    last_shp = int'(gnt_shaper); last_vld = int'(gnt_shaper_vld && !gnt_idle);
  endtask

  initial begin
    int cnt, hs, hc, hi;
    void'($urandom(32'd20240611));
    for (int s = 0; s < N; s++) begin
      set_sh(s, 0, 1, 1, 1, 0, 0, 0);
      m_acc[s] = 0; m_ivl[s] = 0; m_chp[s] = CH - 1;
    end
    m_rr = N - 1;
    repeat (3) @(negedge clk);
    chk("R11 valid low in reset", int'(gnt_valid), 0);
    rst_n = 1'b1;
    next_grant("R1 first grant / R10 empty", 1);

    // R3: num 1 / den 4 alone -> one in four slots
    set_sh(0, 1, 1, 4, 1, 0, 0, 1);
    cnt = 0;
    for (int i = 0; i < 12; i++) begin
      next_grant("R3 average rate", 1);
      if (last_vld != 0 && last_shp == 0) cnt++;
    end
    chk("R3 grants in 12 slots", cnt, 3);

    // R4: peak spacing 3
    set_sh(0, 1, 1, 1, 1, 0, 0, 0);
    set_sh(1, 1, 1, 1, 3, 0, 0, 2);
    cnt = 0;
    for (int i = 0; i < 12; i++) begin
      next_grant("R4 peak interval", 1);
      if (last_vld != 0 && last_shp == 1) cnt++;
    end
    chk("R4 grants in 12 slots", cnt, 4);

    // R5: higher priority wins
    set_sh(0, 2, 1, 1, 1, 0, 0, 1);
    set_sh(1, 5, 1, 1, 1, 0, 0, 1);
    for (int i = 0; i < 6; i++) next_grant("R5 priority", 1);

    // R6: equal priorities rotate
    for (int s = 0; s < N; s++) set_sh(s, 4, 1, 1, 1, 0, 0, 4'b0001 << s);
    for (int i = 0; i < 8; i++) next_grant("R6 round robin", 1);

    // R7: generator 2/3 throttles data shaper
    for (int s = 0; s < N; s++) set_sh(s, 0, 1, 1, 1, 0, 0, 0);
    set_sh(0, 7, 1, 1, 1, 0, 0, 1);
    set_sh(3, 0, 2, 3, 1, 1, 0, 0);
    cnt = 0;
    for (int i = 0; i < 12; i++) begin
      next_grant("R7 idle generator", 1);
      if (last_vld != 0) cnt++;
    end
    chk("R7 data grants in 12 slots", cnt, 4);

    // R8: aggregate rotation over active channels, then one drops
    set_sh(3, 0, 1, 1, 1, 0, 0, 0);
    set_sh(0, 0, 1, 1, 1, 0, 0, 0);
    set_sh(2, 3, 1, 1, 1, 0, 1, 4'b1011);
    for (int i = 0; i < 6; i++) next_grant("R8 aggregate share", 1);
    b_act[2] = 4'b1001;
    for (int i = 0; i < 4; i++) next_grant("R8 aggregate share", 1);

    // R9: non-aggregate lowest active channel
    set_sh(2, 3, 1, 1, 1, 0, 0, 4'b1010);
    for (int i = 0; i < 4; i++) next_grant("R9 lowest channel", 1);

    // R10: nothing active -> idle grant
    b_act[2] = 0;
    for (int i = 0; i < 3; i++) next_grant("R10 empty slot", 1);

    // R2: backpressure holds the grant
    b_act[2] = 4'b0100;
    next_grant("R2 before stall", 1);
    @(negedge clk); gnt_ready = 1'b0;
    next_grant("R2 stalled grant", 0);
    hs = int'(gnt_shaper); hc = int'(gnt_chan); hi = int'(gnt_idle);
    for (int i = 0; i < 20; i++) begin
      @(negedge clk);
      chk("R2 held valid", int'(gnt_valid), 1);
      chk("R2 held fields", int'(gnt_shaper) * 100 + int'(gnt_chan) * 10 + int'(gnt_idle), hs * 100 + hc * 10 + hi);
    end
    gnt_ready = 1'b1;
    next_grant("R2 decision at acceptance", 0);
    chk("R2 immediate reissue", int'(gnt_valid), 1);
    next_grant("R2 after stall", 1);

    // random configurations
    for (int r = 0; r < 30; r++) begin
      for (int s = 0; s < N; s++) begin
        int de;
        de = int'($urandom_range(1, 8));
        set_sh(s, int'($urandom_range(0, 7)), int'($urandom_range(1, de)), de,
               int'($urandom_range(0, 3)), ($urandom_range(0, 7) == 0) ? 1 : 0,
               int'($urandom_range(0, 1)), int'($urandom_range(0, 15)));
      end
      for (int i = 0; i < 10; i++) next_grant("R3/R4/R5/R6/R7/R8/R9/R10 random", 1);
    end

    summary();
    $finish;
  end
endmodule